// File: doc/BRIEF.md
# Soft Output Stage for a Row/Column Decoder Without Competitor Words

This block produces the updated soft values for every symbol of one row or column of a product-code matrix in a single clock. It receives the decided-word bits, the smallest test-pattern metric and a reliability estimate (beta). It also receives the soft values from the previous half-iteration and the soft values from the channel. No competitor codeword is available, so all symbols share one reliability magnitude, `beta - minMetric`. Each symbol takes its sign from its own decided bit.

For each symbol the block forms the extrinsic value from the reliability and the previous soft value. It then damps the extrinsic value by a power of two selected by a 2-bit code. Last, it adds the channel value and saturates the result. All arithmetic works on sign-magnitude numbers.

One registered stage sits at the output, and a valid flag follows it. A decoding pipeline feeds one vector per valid cycle, and the same unit is reused for each half-iteration.

Top module: `softOutputTop`

## Requirements
- R1: While reset is asserted, and after it is released with no valid input, `outValid` is 0 and every bit of `newSoft` is 0.
- R2: An input accepted with `inValid` high at a clock edge appears on `newSoft`, with `outValid` high, after that edge. A cycle with `inValid` low drives `outValid` low at the next edge and leaves `newSoft` unchanged, whatever the other inputs do.
- R3: The reliability magnitude is `beta - minMetric` when `beta > minMetric` and 0 otherwise. It is negative for symbol i when decided bit i is 1 and positive when it is 0.
- R4: The extrinsic value of symbol i is the signed reliability minus the signed previous soft value of symbol i. A previous soft value with magnitude 0 counts as 0 whatever its sign bit.
- R5: The damping code k (0..3) divides the extrinsic value by 2^k. The magnitude is shifted right by k, so the result truncates toward zero and keeps its sign.
- R6: The new soft value of symbol i is the signed channel value of symbol i plus the damped extrinsic value. The sum saturates to +15 or -15.
- R7: A result of zero is always encoded with its sign bit 0.
- R8: A soft value is Q=5 bits: bit 4 is the sign (1 means negative) and bits 3:0 are the magnitude. Symbol i occupies bits `[5*i +: 5]` of each soft vector, and decided bit i belongs to symbol i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input vector present this cycle |
| alphaCode | input | 2 | Damping shift amount k (divide by 2^k) |
| decidedBits | input | N (32) | Decided word, one bit per symbol |
| beta | input | MW (7) | Reliability estimate, unsigned |
| minMetric | input | MW (7) | Metric of the decided word, unsigned |
| prevSoft | input | N*Q (160) | Previous half-iteration soft values, sign-magnitude |
| chanSoft | input | N*Q (160) | Channel soft values, sign-magnitude |
| outValid | output | 1 | `newSoft` holds a fresh result |
| newSoft | output | N*Q (160) | Updated soft values, sign-magnitude, saturated |

## Verification
The lane properties assume that the shared reliability magnitude never exceeds 2^MW-1 and that a previous soft magnitude fits in Q-1 bits. The widened internal magnitudes then cannot wrap before saturation. The stimulus uses only legal codes on every port, including negative-zero codes on the soft inputs. It sweeps all 2048 combinations of decided bit, previous code and channel code across the lanes. This sweep runs for each damping code and for beta/metric pairs with positive, zero and clamped differences. Input-dependent properties are evaluated only while reset is low, after the stimulus has driven defined values.

// File: rtl/softOutPkg.sv
package softOutPkg;
  // Width of the damping shift code.
  localparam int SHIFT_W = 2;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic               loadEn;
    logic [SHIFT_W-1:0] shiftAmt;
  } stepStrobe_t;
endpackage

// File: rtl/softOutLane.sv
module softOutLane #(
  parameter int Q  = 5,
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] fMag,
  input  logic          dwBit,
  input  logic [Q-1:0]  prevCode,
  input  logic [Q-1:0]  chanCode,
  input  logic [1:0]    shiftAmt,
  output logic [Q-1:0]  nextCode
);
  localparam int MAG = Q - 1;
  localparam int EW  = MW + 1;
  localparam int SW  = EW + 1;
  localparam logic [SW-1:0] MAXMAG = SW'((1 << MAG) - 1);

  logic [EW-1:0]  fExt, pExt, wMag, dampMag;
  logic           wSign, prevNegSign;
  logic [SW-1:0]  dExt, cExt, sumMag;
  logic           sumSign;
  logic [MAG-1:0] outMag;
  logic           outSign;

  always_comb begin
    fExt        = EW'(fMag);
    pExt        = EW'(prevCode[MAG-1:0]);
    prevNegSign = ~prevCode[MAG];
    // extrinsic: F + (-R'), sign-magnitude add
    if (dwBit == prevNegSign) begin
      wMag  = fExt + pExt;
      wSign = dwBit;
    end else if (fExt >= pExt) begin
      wMag  = fExt - pExt;
      wSign = dwBit;
    end else begin
      wMag  = pExt - fExt;
      wSign = prevNegSign;
    end
    // damping by power of two
    dampMag = wMag >> shiftAmt;
    dExt    = SW'(dampMag);
    cExt    = SW'(chanCode[MAG-1:0]);
    // channel addition
    if (wSign == chanCode[MAG]) begin
      sumMag  = cExt + dExt;
      sumSign = wSign;
    end else if (cExt >= dExt) begin
      sumMag  = cExt - dExt;
      sumSign = chanCode[MAG];
    end else begin
      sumMag  = dExt - cExt;
      sumSign = wSign;
    end
    outMag  = (sumMag > MAXMAG) ? MAXMAG[MAG-1:0] : sumMag[MAG-1:0];
    outSign = (sumMag != '0) && sumSign;
  end

  assign nextCode = {outSign, outMag};

  // R6: a vanishing damped term leaves the channel magnitude intact
  assert_damp_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (dampMag == '0) |-> (outMag == chanCode[MAG-1:0]));

  // R6: like-signed terms never shrink the channel magnitude nor flip its sign
  assert_same_sign_R6: assert property (@(posedge clk) disable iff (rst)
    ((chanCode[MAG-1:0] != '0) && (dampMag != '0) && (wSign == chanCode[MAG]))
      |-> ((outSign == chanCode[MAG]) && (outMag >= chanCode[MAG-1:0])));
endmodule

// File: rtl/softOutDatapath.sv
module softOutDatapath
  import softOutPkg::*;
#(
  parameter int N  = 32,
  parameter int Q  = 5,
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  stepStrobe_t   strb,
  input  logic [MW-1:0] beta,
  input  logic [MW-1:0] minMetric,
  input  logic [N-1:0]  dwVec,
  input  logic [N*Q-1:0] prevVec,
  input  logic [N*Q-1:0] chanVec,
  output logic [N*Q-1:0] outVec
);
  localparam int MAG = Q - 1;

  logic [MW-1:0]  fMag;
  logic [N*Q-1:0] laneOut;

  // shared reliability magnitude, clamped at zero
  assign fMag = (beta > minMetric) ? (beta - minMetric) : '0;

  for (genvar i = 0; i < N; i++) begin : gLane
    softOutLane #(.Q(Q), .MW(MW)) lane_i (
      .clk      (clk),
      .rst      (rst),
      .fMag     (fMag),
      .dwBit    (dwVec[i]),
      .prevCode (prevVec[i*Q +: Q]),
      .chanCode (chanVec[i*Q +: Q]),
      .shiftAmt (strb.shiftAmt),
      .nextCode (laneOut[i*Q +: Q])
    );

    // R7: registered outputs never carry negative zero
    assert_no_negzero_R7: assert property (@(posedge clk) disable iff (rst)
      !(outVec[i*Q+MAG] && (outVec[i*Q +: MAG] == '0)));
  end

  always_ff @(posedge clk) begin
    if (rst) outVec <= '0;
    else if (strb.loadEn) outVec <= laneOut;
  end
endmodule

// File: rtl/softOutControl.sv
module softOutControl
  import softOutPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [SHIFT_W-1:0] alphaCode,
  output stepStrobe_t        strb,
  output logic               outValid
);
  always_comb begin
    strb.loadEn   = inValid;
    strb.shiftAmt = alphaCode;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
endmodule

// File: rtl/softOutputTop.sv
module softOutputTop
  import softOutPkg::*;
#(
  parameter int N  = 32,
  parameter int Q  = 5,
  parameter int MW = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  input  logic [1:0]     alphaCode,
  input  logic [N-1:0]   decidedBits,
  input  logic [MW-1:0]  beta,
  input  logic [MW-1:0]  minMetric,
  input  logic [N*Q-1:0] prevSoft,
  input  logic [N*Q-1:0] chanSoft,
  output logic           outValid,
  output logic [N*Q-1:0] newSoft
);
  stepStrobe_t strb;

  softOutControl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .alphaCode (alphaCode),
    .strb      (strb),
    .outValid  (outValid)
  );

  softOutDatapath #(.N(N), .Q(Q), .MW(MW)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .beta      (beta),
    .minMetric (minMetric),
    .dwVec     (decidedBits),
    .prevVec   (prevSoft),
    .chanVec   (chanSoft),
    .outVec    (newSoft)
  );

  // R2: idle cycles keep the result stable
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(newSoft));
endmodule

// File: tb/softOutputTop_tb.sv
module softOutputTop_tb_top;
  localparam int N    = 32;
  localparam int Q    = 5;
  localparam int MW   = 7;
  localparam int MB   = Q - 1;
  localparam int MAXM = (1 << MB) - 1;
  localparam int MASK = (1 << Q) - 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           inValid = 1'b0;
  logic [1:0]     alphaCode = '0;
  logic [N-1:0]   decidedBits = '0;
  logic [MW-1:0]  beta = '0;
  logic [MW-1:0]  minMetric = '0;
  logic [N*Q-1:0] prevSoft = '0;
  logic [N*Q-1:0] chanSoft = '0;
  logic           outValid;
  logic [N*Q-1:0] newSoft;

  int  nVec = 0;
  int  nBad = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  softOutputTop #(.N(N), .Q(Q), .MW(MW)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .alphaCode(alphaCode),
    .decidedBits(decidedBits), .beta(beta), .minMetric(minMetric),
    .prevSoft(prevSoft), .chanSoft(chanSoft),
    .outValid(outValid), .newSoft(newSoft)
  );

  function automatic int smToInt(logic [Q-1:0] c);
    int m;
    m = int'(c[MB-1:0]);
    return c[MB] ? -m : m;
  endfunction

  // integer model: R3 R4 R5 R6 R7 R8
  function automatic logic [Q-1:0] refLane(int fm, logic dw, logic [Q-1:0] p,
                                           logic [Q-1:0] ch, int k);
    int f, w, d, s;
    f = dw ? -fm : fm;
    w = f - smToInt(p);
    d = w / (1 << k);
    s = smToInt(ch) + d;
    if (s > MAXM) s = MAXM;
    if (s < -MAXM) s = -MAXM;
    if (s < 0) return {1'b1, MB'(-s)};
    return {1'b0, MB'(s)};
  endfunction

  int betas [6] = '{20, 5, 127, 10, 40, 3};
  int mins  [6] = '{5, 20, 0, 10, 31, 1};

  initial begin
    logic [N*Q-1:0] saved;
    repeat (3) @(negedge clk);
    // R1: reset state during reset
    nVec++;
    if (outValid !== 1'b0 || newSoft !== '0) begin
      nBad++;
      $display("FAIL R1 in reset: outValid=%b newSoft=%h expected 0/0", outValid, newSoft);
    end
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: after release with no valid input
    nVec++;
    if (outValid !== 1'b0 || newSoft !== '0) begin
      nBad++;
      $display("FAIL R1 after release: outValid=%b newSoft=%h expected 0/0", outValid, newSoft);
    end

    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 6; p++) begin
        for (int v = 0; v < 64; v++) begin
          int  fm;
          bit  bad;
          alphaCode = 2'(k);
          beta      = MW'(betas[p]);
          minMetric = MW'(mins[p]);
          for (int i = 0; i < N; i++) begin
            int c;
            c = v * N + i;
            chanSoft[i*Q +: Q] = Q'(c & MASK);
            prevSoft[i*Q +: Q] = Q'((c >> Q) & MASK);
            decidedBits[i]     = 1'((c >> (2*Q)) & 1);
          end
          inValid = 1'b1;
          @(negedge clk);
          inValid = 1'b0;
          fm  = (betas[p] > mins[p]) ? betas[p] - mins[p] : 0;
          bad = 1'b0;
          nVec++;
          // R2 result timing, R3/R4/R5/R6/R7/R8 lane values
          if (outValid !== 1'b1) begin
            bad = 1'b1;
            $display("FAIL R2 outValid=%b expected 1", outValid);
          end
          for (int i = 0; i < N; i++) begin
            logic [Q-1:0] exp;
            exp = refLane(fm, decidedBits[i], prevSoft[i*Q +: Q], chanSoft[i*Q +: Q], k);
            if (newSoft[i*Q +: Q] !== exp) begin
              bad = 1'b1;
              $display("FAIL R6 k=%0d beta=%0d min=%0d lane=%0d got=%b expected=%b",
                       k, betas[p], mins[p], i, newSoft[i*Q +: Q], exp);
            end
          end
          if (bad) nBad++;
        end
        // R2: idle cycle holds result while inputs change
        saved       = newSoft;
        chanSoft    = ~chanSoft;
        prevSoft    = ~prevSoft;
        decidedBits = ~decidedBits;
        alphaCode   = ~alphaCode;
        @(negedge clk);
        nVec++;
        if (outValid !== 1'b0 || newSoft !== saved) begin
          nBad++;
          $display("FAIL R2 hold: outValid=%b newSoft=%h expected 0/%h", outValid, newSoft, saved);
        end
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nBad++;
      $display("FAIL R2 watchdog: run did not complete, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule